// File: doc/BRIEF.md
# Integer and 48-bit Float Converter

This block converts in both directions between 24-bit two's-complement integers and a 48-bit floating word. The float word has a sign bit, a 7-bit exponent with a bias of 64, and a 40-bit fraction with a hidden leading one. Integer-to-float serves a "make float" operation. Float-to-integer serves a "fix to integer" operation. The float side of the block is presented as six byte lanes in memory order, so a load/store unit can move the word directly to and from byte-addressed memory.

A conversion starts with a one-cycle request and a direction select. The block captures its operand and spends one cycle busy. In the cycle after that it raises a one-cycle done pulse, and the result sits on its output. Results hold until the next conversion in the same direction replaces them. Float-to-integer results that do not fit in 24 bits saturate and raise an overflow flag.

Top module: `flt48_cvt`

## Requirements
- R1: After reset, busy_o, done_o and ovf_o are low, and int_o and flt_bytes_o are zero.
- R2: A request is accepted on a rising edge where req_i is high and busy_o is low. busy_o is then high for exactly one cycle. done_o is then high for exactly one cycle, and the result is valid in that done cycle.
- R3: A request made while busy_o is high is ignored. It produces no extra done pulse, and it does not change the result of the conversion already running.
- R4: With dir_i = 0 (integer to float), a nonzero integer gives a word with the following fields. Bit 47 is the sign. Bits 46:40 hold 64 plus the position of the leading one of the magnitude. Bits 39:0 hold the bits below that leading one, left-aligned. The value of the word is (1 + fraction/2^40) × 2^(exponent − 64), negated if the sign is set.
- R5: Integer zero converts to the all-zero word.
- R6: Byte lane k of flt_bytes_i and flt_bytes_o (bits 8k+7:8k) is the byte at memory address base+k. The least significant byte of the word sits in lane 0, and the sign bit is bit 7 of lane 5.
- R7: With dir_i = 1 (float to integer), the value is truncated toward zero. Any word whose exponent field is below 64 gives 0.
- R8: The all-zero word converts to integer 0 with ovf_o low.
- R9: If the truncated value is above 2^23 − 1, int_o becomes 24'h7FFFFF. If it is below −2^23, int_o becomes 24'h800000. In both cases ovf_o is high. A value that truncates to exactly −2^23 gives 24'h800000 with ovf_o low.
- R10: An integer-to-float conversion leaves int_o unchanged and clears ovf_o. A float-to-integer conversion leaves flt_bytes_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a conversion |
| dir_i | input | 1 | 0: integer to float, 1: float to integer |
| int_i | input | 24 | Integer operand |
| flt_bytes_i | input | 48 | Float operand as six byte lanes in address order |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| int_o | output | 24 | Integer result |
| flt_bytes_o | output | 48 | Float result as six byte lanes in address order |
| ovf_o | output | 1 | Saturation on the last float-to-integer conversion |

## Verification
The bench targets the saturation edge at exponent field 87. Here a negative word whose fraction has only bits below bit 17 set must give −2^23 with no overflow, and a single higher fraction bit must saturate with overflow. A converter that compared against 2^23 with the wrong sign or the wrong bit range would flag or miss one of these two cases. Negative non-integers such as −1.5 catch a converter that floors instead of truncating; it would return −2 rather than −1. The integer −2^23 and small values such as 1 and 5 catch an off-by-one in the leading-one position or in the fraction alignment; the error shows up as a wrong exponent or a shifted fraction. A request repeated during the busy cycle would, if accepted, cause a second done pulse or corrupt the result.

// File: rtl/flt48_cvt.sv
module flt48_cvt #(
  parameter int IW = 24,
  parameter int EW = 7,
  parameter int FW = 40,
  parameter int NB = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               dir_i,
  input  logic [IW-1:0]      int_i,
  input  logic [8*NB-1:0]    flt_bytes_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [IW-1:0]      int_o,
  output logic [8*NB-1:0]    flt_bytes_o,
  output logic               ovf_o
);
  localparam int WW   = 1 + EW + FW;
  localparam int BIAS = 1 << (EW - 1);
  localparam int PW   = $clog2(IW);
  localparam int SW   = $clog2(FW + 1);
  localparam logic [IW-1:0] MAXPOS = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] MAXNEG = {1'b1, {(IW-1){1'b0}}};

  logic            busy_q, done_q, dir_q, ovf_q;
  logic [IW-1:0]   int_q, int_r;
  logic [WW-1:0]   word_in, flt_q, flt_r;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign word_in[8*g +: 8]     = flt_bytes_i[8*g +: 8];
    assign flt_bytes_o[8*g +: 8] = flt_r[8*g +: 8];
  end

  // integer to float
  logic            sgn_e;
  logic [IW-1:0]   mag_e, norm_e;
  logic [PW-1:0]   pos_e;
  logic [WW-1:0]   enc;

  assign sgn_e = int_q[IW-1];
  assign mag_e = sgn_e ? -int_q : int_q;

  always_comb begin
    pos_e = '0;
    for (int i = 0; i < IW; i++)
      if (mag_e[i]) pos_e = PW'(i);
  end

  assign norm_e = mag_e << (PW'(IW - 1) - pos_e);
  assign enc = (mag_e == '0) ? '0 :
    {sgn_e, EW'(BIAS) + EW'(pos_e), norm_e[IW-2:0], {(FW-IW+1){1'b0}}};

  // float to integer
  logic            sgn_d;
  logic [EW-1:0]   exp_d;
  logic [EW-2:0]   k_d;
  logic [FW:0]     man_d;
  logic [SW-1:0]   sh_d;
  logic [IW-1:0]   mag_d, dec_int;
  logic            dec_ovf;

  assign sgn_d = flt_q[WW-1];
  assign exp_d = flt_q[WW-2:FW];
  assign k_d   = exp_d[EW-2:0];
  assign man_d = {1'b1, flt_q[FW-1:0]};
  assign sh_d  = SW'(FW) - SW'(k_d);
  assign mag_d = IW'(man_d >> sh_d);

  always_comb begin
    dec_int = '0;
    dec_ovf = 1'b0;
    if (flt_q != '0 && exp_d[EW-1]) begin
      if (int'(k_d) >= IW)
        dec_ovf = 1'b1;
      else if (mag_d[IW-1] && (!sgn_d || mag_d[IW-2:0] != '0))
        dec_ovf = 1'b1;
      else
        dec_int = sgn_d ? -mag_d : mag_d;
      if (dec_ovf)
        dec_int = sgn_d ? MAXNEG : MAXPOS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= 1'b0;
      ovf_q  <= 1'b0;
      int_q  <= '0;
      flt_q  <= '0;
      int_r  <= '0;
      flt_r  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (dir_q) begin
          int_r <= dec_int;
          ovf_q <= dec_ovf;
        end else begin
          flt_r <= enc;
          ovf_q <= 1'b0;
        end
      end else if (req_i) begin
        busy_q <= 1'b1;
        dir_q  <= dir_i;
        int_q  <= int_i;
        flt_q  <= word_in;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign int_o  = int_r;
  assign ovf_o  = ovf_q;

  AST_ACCEPT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (done_o && !busy_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_OVF_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (int_o == MAXPOS || int_o == MAXNEG)); // R9
  AST_ENC_EXP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_r != '0) |-> (int'(flt_r[WW-2:FW]) >= BIAS && int'(flt_r[WW-2:FW]) < BIAS + IW)); // R4
  AST_NORM_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_e != '0) |-> norm_e[IW-1]); // R4
endmodule

// File: tb/flt48_cvt_tb_top.sv
module flt48_cvt_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        dir = 1'b0;
  logic [23:0] ival = '0;
  logic [47:0] fval = '0;
  logic        busy, done, ovf;
  logic [23:0] iout;
  logic [47:0] fout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flt48_cvt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .dir_i(dir),
    .int_i(ival), .flt_bytes_i(fval),
    .busy_o(busy), .done_o(done), .int_o(iout),
    .flt_bytes_o(fout), .ovf_o(ovf)
  );

  function automatic logic [47:0] ref_i2f(logic [23:0] v);
    longint mag, frac;
    int p;
    logic s;
    if (v == 0) return 48'h0;
    s = v[23];
    mag = s ? (longint'(1) << 24) - longint'(v) : longint'(v);
    p = $clog2(mag + 1) - 1;
    frac = (mag - (longint'(1) << p)) << (40 - p);
    return {s, 7'(64 + p), 40'(frac)};
  endfunction

  function automatic logic [24:0] ref_f2i(logic [47:0] w);
    real val;
    int e;
    if (w == 0) return 25'h0;
    e = int'(w[46:40]) - 64;
    val = (1.0 + real'(longint'(w[39:0])) / (2.0 ** 40)) * (2.0 ** e);
    if (w[47]) val = -val;
    if (val >= 8388608.0) return {1'b1, 24'h7FFFFF};
    if (val <= -8388609.0) return {1'b1, 24'h800000};
    return {1'b0, 24'($rtoi(val))};
  endfunction

  logic        m_busy, m_done, m_ovf, m_dir;
  logic [23:0] m_int, m_iin;
  logic [47:0] m_flt, m_fin;
  logic [24:0] m_dec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_ovf <= 0; m_int <= 0; m_flt <= 0;
      m_dir <= 0; m_iin <= 0; m_fin <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        m_busy <= 0;
        m_done <= 1;
        if (m_dir) begin
          m_dec = ref_f2i(m_fin);
          m_int <= m_dec[23:0];
          m_ovf <= m_dec[24];
        end else begin
          m_flt <= ref_i2f(m_iin);
          m_ovf <= 0;
        end
      end else if (req) begin
        m_busy <= 1; m_dir <= dir; m_iin <= ival; m_fin <= fval;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", 64'(busy), 64'(m_busy));
      chk("R2 done", 64'(done), 64'(m_done));
      chk("R4 flt", 64'(fout), 64'(m_flt));
      chk("R7 int", 64'(iout), 64'(m_int));
      chk("R9 ovf", 64'(ovf), 64'(m_ovf));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(logic d, logic [23:0] i, logic [47:0] f);
    @(negedge clk); req = 1; dir = d; ival = i; fval = f;
    @(negedge clk); req = 0;
    @(negedge clk);
  endtask

  task automatic f2i(string tag, logic [47:0] w, logic [23:0] ei, logic eo);
    run(1, 24'h0, w);
    chk({tag, " done"}, 64'(done), 64'd1);
    chk({tag, " int"}, 64'(iout), 64'(ei));
    chk({tag, " ovf"}, 64'(ovf), 64'(eo));
  endtask

  task automatic i2f(string tag, logic [23:0] v, logic [47:0] ew);
    run(0, v, 48'h0);
    chk({tag, " flt"}, 64'(fout), 64'(ew));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 ovf", 64'(ovf), 0);
    chk("R1 int", 64'(iout), 0);
    chk("R1 flt", 64'(fout), 0);
    rst_n = 1;
    @(negedge clk);

    i2f("R4 one", 24'd1, 48'h400000000000);
    i2f("R4 five", 24'd5, 48'h424000000000);
    i2f("R4 minus one", 24'hFFFFFF, 48'hC00000000000);
    i2f("R4 most negative", 24'h800000, 48'hD70000000000);
    chk("R6 lane5 sign", 64'(fout[47:40]), 64'hD7);
    chk("R6 lane0", 64'(fout[7:0]), 64'h00);
    i2f("R5 zero", 24'd0, 48'h0);

    f2i("R6 lanes five", 48'h424000000000, 24'd5, 0);
    f2i("R7 one and half", 48'h408000000000, 24'd1, 0);
    f2i("R7 minus one and half", 48'hC08000000000, 24'hFFFFFF, 0);
    f2i("R7 below one", 48'h3F8000000000, 24'd0, 0);
    f2i("R7 just under max", 48'h56FFFFFFFFFF, 24'h7FFFFF, 0);
    f2i("R8 zero word", 48'h0, 24'd0, 0);
    f2i("R9 exact min", 48'hD70000000000, 24'h800000, 0);
    f2i("R9 min plus fraction", 48'hD70000000001, 24'h800000, 0);
    f2i("R9 neg over", 48'hD70000020000, 24'h800000, 1);
    f2i("R9 pos over", 48'h578000000000, 24'h7FFFFF, 1);
    f2i("R9 big neg", 48'hFF0000000000, 24'h800000, 1);
    f2i("R9 big pos", 48'h580000000000, 24'h7FFFFF, 1);

    f2i("R10 setup", 48'h424000000000, 24'd5, 0);
    f2i("R10 setup ovf", 48'h580000000000, 24'h7FFFFF, 1);
    i2f("R10 i2f", 24'd1, 48'h400000000000);
    chk("R10 int kept", 64'(iout), 64'h7FFFFF);
    chk("R10 ovf cleared", 64'(ovf), 0);
    f2i("R10 f2i", 48'h408000000000, 24'd1, 0);
    chk("R10 flt kept", 64'(fout), 64'h400000000000);

    @(negedge clk); req = 1; dir = 0; ival = 24'd5;
    @(negedge clk); dir = 0; ival = 24'd1000;
    @(negedge clk); req = 0;
    chk("R3 done", 64'(done), 1);
    chk("R3 result", 64'(fout), 64'h424000000000);
    @(negedge clk);
    chk("R3 no second done", 64'(done), 0);
    chk("R3 not busy", 64'(busy), 0);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      req = ($urandom % 3) != 0;
      dir = $urandom % 2;
      ival = (($urandom % 8) == 0) ? 24'h0 : 24'($urandom);
      fval = (($urandom % 10) == 0) ? 48'h0 :
             {1'($urandom), 7'(40 + $urandom % 60), 8'($urandom), 32'($urandom)};
    end
    @(negedge clk); req = 0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule